// File: doc/BRIEF.md
# Stereo Step Attenuator

This block applies a separate volume step to each side of a stream of signed stereo PCM samples. A left and a right sample come in together under one valid strobe. Each side has its own 8-bit step code, and the block multiplies the sample by that code over 256. The result goes out at the input width one clock later, and the output strobe is delayed by the same clock.

The top code is a special case: it is promoted to a multiplier of exactly 256/256, so the top step is true unity gain. A code of zero mutes the side it belongs to. Each code is sampled in the same cycle as the stereo pair it scales, so a code change can only take effect between pairs. Between pairs the outputs hold their last values.

Top module: `stereo_attenuator`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is cleared and both output samples are set to zero.
- R2: `out_valid` is high in the cycle after a clock edge that saw `in_valid` high, and low in the cycle after one that saw it low. There is exactly one cycle of latency.
- R3: A step code of 8'hFF (255) gives an output equal to the input sample in every bit, including the most negative 24-bit value.
- R4: A step code of 8'h00 gives an output of zero for any input sample.
- R5: For a step code c from 1 to 254, the output is floor(s*c/256). This is an arithmetic right shift by 8 that rounds toward negative infinity, so -1 with c=1 gives -1.
- R6: The left output uses only `att_left` and the left sample. The right output uses only `att_right` and the right sample. Different codes on the two sides are applied within the same pair.
- R7: The codes are taken only in a cycle with `in_valid` high. When `in_valid` is low, the codes and samples may change and both outputs keep their previous values.
- R8: A non-negative input never produces a negative output, and the output magnitude never exceeds the input magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stereo pair is present this cycle |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| att_left | input | 8 | Left step code, 255 = unity, 0 = mute |
| att_right | input | 8 | Right step code, 255 = unity, 0 = mute |
| out_valid | output | 1 | Output pair is valid this cycle |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The bench drives the following patterns:
- The full-scale extremes and -1 at code 255. These separate a true unity path from a 255/256 multiply.
- Code 0 on mixed samples, to confirm the mute.
- Small negative and positive values at codes 1 and 128. These expose rounding toward zero where flooring is required.
- Pairs with unlike codes on the two sides. These catch crossed or shared codes.
- A back-to-back burst followed by idle cycles in which the codes and samples change. This checks the one-cycle strobe and that nothing moves between pairs.

// File: rtl/stereo_att_pkg.sv
package stereo_att_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CODE_W   = 8;
    localparam int NUM_CH   = 2;

    typedef enum logic [0:0] {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic                       valid;
        logic signed [SAMPLE_W-1:0] left;
        logic signed [SAMPLE_W-1:0] right;
    } stereo_frame_t;

    // Maps a step code onto its multiplier numerator: all-ones becomes 2^w.
    function automatic logic [CODE_W:0] step_to_gain(input logic [CODE_W-1:0] code);
        logic [CODE_W:0] g;
        if (code == {CODE_W{1'b1}}) g = {1'b1, {CODE_W{1'b0}}};
        else                        g = {1'b0, code};
        return g;
    endfunction

endpackage

// File: rtl/att_gain_map.sv
module att_gain_map #(
    parameter int CODE_W = stereo_att_pkg::CODE_W,
    localparam int GAIN_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);

    logic top_code;

    always_comb begin
        top_code = &code;
        if (top_code) gain = {1'b1, {CODE_W{1'b0}}};
        else          gain = {1'b0, code};
    end

endmodule

// File: rtl/att_channel.sv
module att_channel #(
    parameter int SAMPLE_W = stereo_att_pkg::SAMPLE_W,
    parameter int CODE_W   = stereo_att_pkg::CODE_W,
    localparam int GAIN_W  = CODE_W + 1,
    localparam int PROD_W  = SAMPLE_W + CODE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [CODE_W-1:0]          code,
    output logic signed [SAMPLE_W-1:0] result
);

    logic [GAIN_W-1:0]          gain;
    logic signed [PROD_W-1:0]   s_ext;
    logic signed [PROD_W-1:0]   g_ext;
    logic signed [PROD_W-1:0]   prod;
    logic signed [SAMPLE_W-1:0] scaled;
    logic [CODE_W-1:0]          frac;

    att_gain_map #(.CODE_W(CODE_W)) u_map (
        .code (code),
        .gain (gain)
    );

    // |sample| * 2^CODE_W fits in PROD_W signed bits, so the product is exact.
    assign s_ext = {{(PROD_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
    assign g_ext = {{(PROD_W-GAIN_W){1'b0}}, gain};
    assign prod  = s_ext * g_ext;
    // Dropping the low bits of a two's complement value floors it.
    assign {scaled, frac} = prod;

    always_ff @(posedge clk) begin
        if (rst)       result <= '0;
        else if (load) result <= scaled;
    end

    p_exact_frac_r3: assert property (@(posedge clk) disable iff (rst)
        gain[GAIN_W-1] |-> (frac == '0));

    p_unity_r3: assert property (@(posedge clk) disable iff (rst)
        (load && (&code)) |=> (result == $past(sample)));

    p_mute_r4: assert property (@(posedge clk) disable iff (rst)
        (load && (code == '0)) |=> (result == '0));

    p_sign_r8: assert property (@(posedge clk) disable iff (rst)
        (load && !sample[SAMPLE_W-1]) |=> !result[SAMPLE_W-1]);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(result));

endmodule

// File: rtl/stereo_attenuator.sv
module stereo_attenuator
    import stereo_att_pkg::*;
#(
    parameter int SW = stereo_att_pkg::SAMPLE_W,
    parameter int CW = stereo_att_pkg::CODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_left,
    input  logic signed [SW-1:0] in_right,
    input  logic [CW-1:0]        att_left,
    input  logic [CW-1:0]        att_right,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_left,
    output logic signed [SW-1:0] out_right
);

    logic signed [SW-1:0] ch_sample [NUM_CH];
    logic [CW-1:0]        ch_code   [NUM_CH];
    logic signed [SW-1:0] ch_result [NUM_CH];
    logic                 valid_q;

    assign ch_sample[CH_LEFT]  = in_left;
    assign ch_sample[CH_RIGHT] = in_right;
    assign ch_code[CH_LEFT]    = att_left;
    assign ch_code[CH_RIGHT]   = att_right;

    // Both sides load on the same strobe, so a pair always sees one code snapshot.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        att_channel #(.SAMPLE_W(SW), .CODE_W(CW)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .load   (in_valid),
            .sample (ch_sample[ch]),
            .code   (ch_code[ch]),
            .result (ch_result[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= in_valid;
    end

    assign out_valid = valid_q;
    assign out_left  = ch_result[CH_LEFT];
    assign out_right = ch_result[CH_RIGHT];

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_pair_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_left == '0 && out_right == '0));

endmodule

// File: tb/test_stereo_attenuator.sv
module test_stereo_attenuator;

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic signed [23:0] in_left, in_right;
    logic [7:0] att_left, att_right;
    logic out_valid;
    logic signed [23:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic signed [23:0] l;
        logic signed [23:0] r;
        string              tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    stereo_attenuator i_stereo_attenuator (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .att_left(att_left), .att_right(att_right),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic logic signed [23:0] model(input logic signed [23:0] s, input logic [7:0] c);
        longint p;
        if (c == 8'hFF) return s;
        p = longint'(s) * longint'(c);
        return 24'(p >>> 8);
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic signed [23:0] l, input logic signed [23:0] r,
                        input logic [7:0] cl, input logic [7:0] cr, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid  = 1'b1;
        in_left   = l;
        in_right  = r;
        att_left  = cl;
        att_right = cr;
        e.l = model(l, cl);
        e.r = model(r, cr);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compares each output pair against the scoreboard (R2 strobe timing).
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " left"},  out_left,  e.l);
                check({e.tag, " right"}, out_right, e.r);
            end
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0;
        in_left = 24'sd1234; in_right = -24'sd77; att_left = 8'hFF; att_right = 8'hFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 out_left", out_left, 0);
        check("R1 out_right", out_right, 0);
        rst = 1'b0;
        in_valid = 1'b0;

        // R3: unity at top code, extremes
        send(24'sh7FFFFF, -24'sh800000, 8'hFF, 8'hFF, "R3 full scale");
        send(-24'sd1, 24'sd1, 8'hFF, 8'hFF, "R3 small");
        // R4: mute
        send(24'sh7FFFFF, -24'sd5, 8'h00, 8'h00, "R4 mute");
        // R5: flooring and mid codes
        send(-24'sd1, 24'sd255, 8'd1, 8'd1, "R5 code1");
        send(-24'sd3, 24'sd3, 8'd128, 8'd128, "R5 code128");
        send(24'sh7FFFFF, -24'sh800000, 8'd254, 8'd254, "R5 code254");
        send(24'sd256, -24'sd257, 8'd1, 8'd1, "R5 code1 edge");
        // R6: independent codes
        send(24'sd100000, 24'sd100000, 8'hFF, 8'h00, "R6 unlike codes");
        send(-24'sd4096, -24'sd4096, 8'd64, 8'd200, "R6 mixed");
        idle(3);
        wait (sb.size() == 0);

        // R7: codes and samples change while idle; outputs must hold
        send(24'sd51200, -24'sd51200, 8'd100, 8'd50, "R7 before idle");
        @(negedge clk);
        in_valid = 1'b0; in_left = 24'sd9; in_right = 24'sd9;
        att_left = 8'h00; att_right = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            att_left = 8'(i * 37); in_left = 24'(i * 1000);
            check("R7 hold left", out_left, model(24'sd51200, 8'd100));
            check("R7 hold right", out_right, model(-24'sd51200, 8'd50));
            check("R2 idle strobe", out_valid, 0);
        end

        // R8 and R2: back-to-back burst
        for (int k = 0; k < 40; k++) begin
            logic signed [23:0] s;
            s = 24'((k * 212821) ^ (k << 17));
            send(s, -s, 8'(k * 7 + 3), 8'(255 - k * 5), "R8 burst");
        end
        idle(4);
        check("R2 drained", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule